// File: doc/BRIEF.md
# Multi-mode 16-bit PWM timer

This block is a 16-bit timer/counter that produces a pulse-width-modulated waveform in one of sixteen modes, selected by a 4-bit mode input. The mode sets four things: whether the counter runs single-slope (up, then back to zero) or dual-slope (up, then down), where the turning point TOP comes from, when a newly written compare value reaches the active compare register, and at which counter position the overflow flag is raised.

TOP is either a fixed value (full range, 8-bit, 9-bit or 10-bit), the active compare-A register, or the capture/TOP register input. Two sticky flags report a compare match and an overflow, and each has its own clear strobe. A single waveform output is driven from compare matches and the counting direction. Prescaling and the capture logic sit outside this block: a count enable stands in for the prescaler tick, and the capture register value arrives as a plain input.

Top module: `wavetimer16`

## Requirements
- R1: While `rst_n` is low, `count` is 0, `match_flag`, `ovf_flag` and `wave_out` are 0, the counting direction is up and the active compare register is 0.
- R2: The counter advances only on a clock edge where `cnt_en` is 1 and `mode` is not 13; mode 13 is reserved, holds `count` and raises no flag.
- R3: In single-slope modes (0, 4, 5, 6, 7, 12, 14, 15) every enabled edge adds one to `count`, except that from TOP it returns to 0.
- R4: In dual-slope modes (1, 2, 3, 8, 9, 10, 11) the counter rises to TOP, then falls to 0, then rises again; TOP and 0 each last for exactly one enabled edge.
- R5: TOP is 0xFFFF in mode 0, 0x00FF in modes 1 and 5, 0x01FF in modes 2 and 6, 0x03FF in modes 3 and 7, the active compare register in modes 4, 9, 11 and 15, and `cap_in` in modes 8, 10, 12 and 14.
- R6: `ovf_flag` goes to 1 on the edge after an enabled edge where `count` held the overflow position: 0xFFFF in modes 0, 4 and 12; TOP in modes 5, 6, 7, 14 and 15; 0 while counting down in the dual-slope modes.
- R7: The active compare register copies `cmp_in` on every edge in modes 0, 4, 12 and 13; on an enabled edge at count 0 in modes 8 and 9; on an enabled edge at TOP in all other modes.
- R8: `match_flag` goes to 1 on the edge after an enabled edge where `count` equals the active compare register.
- R9: Each flag stays 1 until its clear strobe (`clr_match`, `clr_ovf`) is 1 at an edge; when a set and the matching clear fall on the same edge, the flag is 1 afterwards.
- R10: On a compare match, `wave_out` becomes 1 if counting up and 0 if counting down; in single-slope modes it also becomes 0 at TOP when there is no match at that edge, and it changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable (one counter step per enabled edge) |
| mode | input | 4 | Waveform mode, 0 to 15 |
| cmp_in | input | 16 | Compare-A value written by the host |
| cap_in | input | 16 | Capture/TOP register value |
| clr_match | input | 1 | Clears the match flag |
| clr_ovf | input | 1 | Clears the overflow flag |
| count | output | 16 | Current counter value |
| match_flag | output | 1 | Sticky compare-A match flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| wave_out | output | 1 | Waveform output |

## Verification
A flag can be set by the counter and cleared by its strobe on the same edge; the bench steps a fast-PWM run to the cycle before TOP and then applies the enabled edge together with `clr_ovf`, expecting the overflow flag to read 1 afterwards and to read 0 after a later strobe on an idle edge. The other collision is a compare match landing on the TOP edge of a single-slope mode, where the match must win over the clear-at-TOP of the waveform; the bench reaches it by letting the power-up compare value of zero meet a zero TOP. Per-mode counter sequences and flag positions are judged from hand-computed end values after a known number of enabled edges.

// File: rtl/wavetimer16_pkg.sv
package wavetimer16_pkg;

   localparam int unsigned MODE_W    = 4;
   localparam logic [3:0]  MODE_RSVD = 4'd13;

   typedef enum logic [1:0] {TOP_FIXED, TOP_CMP, TOP_CAP}          top_src_e;
   typedef enum logic [1:0] {UPD_NOW, UPD_AT_TOP, UPD_AT_BOT}      upd_e;
   typedef enum logic [1:0] {OVF_AT_MAX, OVF_AT_TOP, OVF_AT_BOT}   ovf_e;

   // fixed_sel: 0 full range, 1 eight bits, 2 nine bits, 3 ten bits
   typedef struct packed {
      logic       dual;
      logic       halt;
      top_src_e   src;
      logic [1:0] fixed_sel;
      upd_e       upd;
      ovf_e       ovf;
   } mode_cfg_t;

   function automatic mode_cfg_t decode_mode(input logic [MODE_W-1:0] m);
      mode_cfg_t c;
      c = '{dual: 1'b0, halt: 1'b0, src: TOP_FIXED, fixed_sel: 2'd0,
            upd: UPD_NOW, ovf: OVF_AT_MAX};
      unique case (m)
         4'd0: ;
         4'd1, 4'd2, 4'd3: begin
            c.dual = 1'b1; c.fixed_sel = m[1:0];
            c.upd = UPD_AT_TOP; c.ovf = OVF_AT_BOT;
         end
         4'd4:  c.src = TOP_CMP;
         4'd5, 4'd6, 4'd7: begin
            c.fixed_sel = m[1:0]; c.upd = UPD_AT_TOP; c.ovf = OVF_AT_TOP;
         end
         4'd8:  begin c.dual = 1'b1; c.src = TOP_CAP; c.upd = UPD_AT_BOT; c.ovf = OVF_AT_BOT; end
         4'd9:  begin c.dual = 1'b1; c.src = TOP_CMP; c.upd = UPD_AT_BOT; c.ovf = OVF_AT_BOT; end
         4'd10: begin c.dual = 1'b1; c.src = TOP_CAP; c.upd = UPD_AT_TOP; c.ovf = OVF_AT_BOT; end
         4'd11: begin c.dual = 1'b1; c.src = TOP_CMP; c.upd = UPD_AT_TOP; c.ovf = OVF_AT_BOT; end
         4'd12: c.src = TOP_CAP;
         4'd13: c.halt = 1'b1;
         4'd14: begin c.src = TOP_CAP; c.upd = UPD_AT_TOP; c.ovf = OVF_AT_TOP; end
         default: begin c.src = TOP_CMP; c.upd = UPD_AT_TOP; c.ovf = OVF_AT_TOP; end
      endcase
      return c;
   endfunction

endpackage

// File: rtl/wt_counter.sv
module wt_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             dual,
   input  logic [CNT_W-1:0] top_val,
   output logic [CNT_W-1:0] count,
   output logic             dir_up
);

   logic [CNT_W-1:0] nxt_cnt;
   logic             nxt_up;

   always_comb begin
      nxt_cnt = count;
      nxt_up  = dir_up;
      if (!dual) begin
         nxt_up  = 1'b1;
         nxt_cnt = (count == top_val) ? '0 : count + 1'b1;
      end else if (dir_up) begin
         if (count >= top_val) begin
            nxt_up  = 1'b0;
            nxt_cnt = (count == '0) ? '0 : count - 1'b1;
         end else begin
            nxt_cnt = count + 1'b1;
         end
      end else begin
         if (count == '0) begin
            nxt_up  = 1'b1;
            nxt_cnt = (top_val == '0) ? '0 : count + 1'b1;
         end else begin
            nxt_cnt = count - 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= '0;
         dir_up <= 1'b1;
      end else if (tick) begin
         count  <= nxt_cnt;
         dir_up <= nxt_up;
      end
   end

endmodule

// File: rtl/wt_cmp_buf.sv
module wt_cmp_buf #(
   parameter int unsigned CNT_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick,
   input  wavetimer16_pkg::upd_e upd,
   input  logic                  at_top,
   input  logic                  at_bot,
   input  logic [CNT_W-1:0]      cmp_in,
   output logic [CNT_W-1:0]      cmp_act
);
   import wavetimer16_pkg::*;

   logic load;

   always_comb begin
      unique case (upd)
         UPD_AT_TOP: load = tick & at_top;
         UPD_AT_BOT: load = tick & at_bot;
         default:    load = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cmp_act <= '0;
      else if (load) cmp_act <= cmp_in;
   end

endmodule

// File: rtl/wt_flag.sv
module wt_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr,
   output logic flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag <= 1'b0;
      else if (set_evt) flag <= 1'b1;
      else if (clr)     flag <= 1'b0;
   end

endmodule

// File: rtl/wt_wave.sv
module wt_wave (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic dual,
   input  logic dir_up,
   input  logic hit,
   input  logic at_top,
   output logic wave_out
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wave_out <= 1'b0;
      end else if (tick) begin
         if (hit)                 wave_out <= dual ? dir_up : 1'b1;
         else if (!dual && at_top) wave_out <= 1'b0;
      end
   end

endmodule

// File: rtl/wavetimer16.sv
module wavetimer16 #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic [3:0]       mode,
   input  logic [CNT_W-1:0] cmp_in,
   input  logic [CNT_W-1:0] cap_in,
   input  logic             clr_match,
   input  logic             clr_ovf,
   output logic [CNT_W-1:0] count,
   output logic             match_flag,
   output logic             ovf_flag,
   output logic             wave_out
);
   import wavetimer16_pkg::*;

   localparam int unsigned     N_FLAGS  = 2;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] TOP_8   = CNT_W'(255);
   localparam logic [CNT_W-1:0] TOP_9   = CNT_W'(511);
   localparam logic [CNT_W-1:0] TOP_10  = CNT_W'(1023);

   if (CNT_W < 10) begin : g_bad_width
      $error("wavetimer16: CNT_W must be at least 10 to hold the fixed TOP values");
   end

   mode_cfg_t        cfg;
   logic             tick, dir_up, at_top, at_bot, at_max, hit, ovf_evt;
   logic [CNT_W-1:0] cmp_act, top_val, fixed_top;

   assign cfg  = decode_mode(mode);
   assign tick = cnt_en & ~cfg.halt;

   always_comb begin
      unique case (cfg.fixed_sel)
         2'd1:    fixed_top = TOP_8;
         2'd2:    fixed_top = TOP_9;
         2'd3:    fixed_top = TOP_10;
         default: fixed_top = CNT_MAX;
      endcase
      unique case (cfg.src)
         TOP_CMP: top_val = cmp_act;
         TOP_CAP: top_val = cap_in;
         default: top_val = fixed_top;
      endcase
   end

   assign at_top = (count == top_val);
   assign at_bot = (count == '0);
   assign at_max = (count == CNT_MAX);
   assign hit    = tick & (count == cmp_act);

   always_comb begin
      unique case (cfg.ovf)
         OVF_AT_TOP: ovf_evt = tick & at_top;
         OVF_AT_BOT: ovf_evt = tick & at_bot & ~dir_up;
         default:    ovf_evt = tick & at_max;
      endcase
   end

   wt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .dual(cfg.dual),
      .top_val(top_val), .count(count), .dir_up(dir_up)
   );

   wt_cmp_buf #(.CNT_W(CNT_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .tick(tick), .upd(cfg.upd),
      .at_top(at_top), .at_bot(at_bot), .cmp_in(cmp_in), .cmp_act(cmp_act)
   );

   wt_wave u_wave (
      .clk(clk), .rst_n(rst_n), .tick(tick), .dual(cfg.dual),
      .dir_up(dir_up), .hit(hit), .at_top(at_top), .wave_out(wave_out)
   );

   // flag 0: compare match, flag 1: overflow
   logic [N_FLAGS-1:0] flag_set, flag_clr, flag_q;
   assign flag_set = {ovf_evt, hit};
   assign flag_clr = {clr_ovf, clr_match};

   for (genvar gi = 0; gi < N_FLAGS; gi++) begin : g_flag
      wt_flag u_flag (
         .clk(clk), .rst_n(rst_n), .set_evt(flag_set[gi]),
         .clr(flag_clr[gi]), .flag(flag_q[gi])
      );
   end

   assign match_flag = flag_q[0];
   assign ovf_flag   = flag_q[1];

endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_en,
   input logic [3:0]       mode,
   input logic             clr_match,
   input logic             clr_ovf,
   input logic [CNT_W-1:0] count,
   input logic             match_flag,
   input logic             ovf_flag,
   input logic             wave_out
);
   import wavetimer16_pkg::*;

   logic stepping;
   assign stepping = cnt_en && (mode != MODE_RSVD);

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> count == $past(count)); // R2

   AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_RSVD) |=> (count == $past(count)) && !$rose(ovf_flag) && !$rose(match_flag)); // R2

   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      stepping |=> (count == $past(count) + 1'b1) || (count == $past(count) - 1'b1) || (count == '0)); // R3

   AST_OVF_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovf_flag && !stepping) |=> !ovf_flag); // R6

   AST_MATCH_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!match_flag && !stepping) |=> !match_flag); // R8

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !clr_ovf) |=> ovf_flag); // R9

   AST_MATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (match_flag && !clr_match) |=> match_flag); // R9

   AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_ovf && !stepping) |=> !ovf_flag); // R9

   AST_WAVE_STILL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !stepping |=> $stable(wave_out)); // R10

endmodule

bind wavetimer16 wt_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode(mode),
   .clr_match(clr_match), .clr_ovf(clr_ovf), .count(count),
   .match_flag(match_flag), .ovf_flag(ovf_flag), .wave_out(wave_out)
);

// File: tb/wavetimer16_tb.sv
module wavetimer16_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b0;
   logic [3:0]  mode = '0;
   logic [15:0] cmp_in = '0;
   logic [15:0] cap_in = '0;
   logic        clr_match = 1'b0;
   logic        clr_ovf = 1'b0;
   logic [15:0] count;
   logic        match_flag, ovf_flag, wave_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   wavetimer16 #(.CNT_W(16)) u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode(mode),
      .cmp_in(cmp_in), .cap_in(cap_in), .clr_match(clr_match), .clr_ovf(clr_ovf),
      .count(count), .match_flag(match_flag), .ovf_flag(ovf_flag), .wave_out(wave_out)
   );

   typedef struct packed {
      logic [3:0]  m;
      logic [15:0] cmp;
      logic [15:0] cap;
      logic [31:0] n;
      logic [15:0] cnt;
      logic        ovf;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{4'd0,  16'd0, 16'd0, 32'd5,     16'd5,    1'b0},  // R3 free count
      '{4'd5,  16'd0, 16'd0, 32'd256,   16'd0,    1'b1},  // R5 R6 fast 8-bit wraps at TOP
      '{4'd5,  16'd0, 16'd0, 32'd255,   16'd255,  1'b0},  // R5 one edge before TOP
      '{4'd1,  16'd0, 16'd0, 32'd1,     16'd1,    1'b0},  // R4 starts upward
      '{4'd1,  16'd0, 16'd0, 32'd256,   16'd254,  1'b0},  // R4 turns at TOP once
      '{4'd1,  16'd0, 16'd0, 32'd510,   16'd0,    1'b0},  // R4 reaches bottom
      '{4'd1,  16'd0, 16'd0, 32'd511,   16'd1,    1'b1},  // R6 bottom while down
      '{4'd12, 16'd0, 16'd9, 32'd10,    16'd0,    1'b0},  // R5 R6 CTC on capture, no flag at TOP
      '{4'd14, 16'd0, 16'd9, 32'd10,    16'd0,    1'b1},  // R5 R6 fast on capture
      '{4'd8,  16'd0, 16'd4, 32'd9,     16'd1,    1'b1},  // R4 R6 dual on capture
      '{4'd10, 16'd0, 16'd4, 32'd8,     16'd0,    1'b0},  // R4 dual on capture
      '{4'd4,  16'd6, 16'd0, 32'd7,     16'd0,    1'b0},  // R5 R7 CTC on compare
      '{4'd15, 16'd5, 16'd0, 32'd7,     16'd0,    1'b1},  // R7 TOP loaded at TOP
      '{4'd9,  16'd3, 16'd0, 32'd5,     16'd2,    1'b1},  // R7 TOP loaded at bottom
      '{4'd0,  16'd0, 16'd0, 32'd65536, 16'd0,    1'b1},  // R6 flag at MAX
      '{4'd13, 16'd0, 16'd0, 32'd20,    16'd0,    1'b0},  // R2 reserved holds
      '{4'd3,  16'd0, 16'd0, 32'd1024,  16'd1022, 1'b0},  // R5 dual 10-bit
      '{4'd7,  16'd0, 16'd0, 32'd1024,  16'd0,    1'b1},  // R5 fast 10-bit
      '{4'd2,  16'd0, 16'd0, 32'd511,   16'd511,  1'b0},  // R5 dual 9-bit at TOP
      '{4'd6,  16'd0, 16'd0, 32'd512,   16'd0,    1'b1}   // R5 fast 9-bit
   };

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // called at a falling edge; leaves one idle rising edge after reset
   task automatic do_reset(input logic [3:0] m, input logic [15:0] cv, input logic [15:0] tv);
      cnt_en = 1'b0; clr_match = 1'b0; clr_ovf = 1'b0;
      mode = m; cmp_in = cv; cap_in = tv;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic run(input int n);
      cnt_en = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      cnt_en = 1'b0;
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      // R1 reset state
      check("R1 count", count, 0);
      check("R1 match_flag", match_flag, 0);
      check("R1 ovf_flag", ovf_flag, 0);
      check("R1 wave_out", wave_out, 0);

      for (int i = 0; i < NV; i++) begin
         do_reset(VECS[i].m, VECS[i].cmp, VECS[i].cap);
         run(int'(VECS[i].n));
         check($sformatf("R3/R4 row %0d count", i), count, int'(VECS[i].cnt));
         check($sformatf("R6 row %0d ovf", i), ovf_flag, int'(VECS[i].ovf));
      end

      // R8 R10 dual-slope: match at 0 going up, buffered compare (R7)
      do_reset(4'd1, 16'd100, 16'd0);
      run(1);
      check("R8 match after first edge", match_flag, 1);
      check("R10 wave set counting up", wave_out, 1);
      clr_match = 1'b1; @(negedge clk); clr_match = 1'b0;
      check("R9 match cleared", match_flag, 0);
      run(254);
      check("R7 compare still buffered", match_flag, 0);
      run(155);
      check("R4 count on way down", count, 100);
      check("R10 wave held", wave_out, 1);
      run(1);
      check("R8 match counting down", match_flag, 1);
      check("R10 wave cleared counting down", wave_out, 0);
      check("R4 count falls", count, 99);

      // R10 single-slope wave
      do_reset(4'd14, 16'd4, 16'd9);
      run(14);
      check("R10 wave cleared at TOP", wave_out, 0);
      check("R3 count after wrap", count, 4);
      run(1);
      check("R10 wave set on match", wave_out, 1);

      // R9 set and clear on the same edge
      do_reset(4'd14, 16'd0, 16'd9);
      run(9);
      check("R6 no flag before TOP", ovf_flag, 0);
      cnt_en = 1'b1; clr_ovf = 1'b1;
      @(negedge clk);
      cnt_en = 1'b0; clr_ovf = 1'b0;
      check("R9 set wins over clear", ovf_flag, 1);
      clr_ovf = 1'b1; @(negedge clk); clr_ovf = 1'b0;
      check("R9 clear on idle edge", ovf_flag, 0);

      // R7 immediate compare update in mode 0
      do_reset(4'd0, 16'd50, 16'd0);
      run(5);
      check("R8 no match yet", match_flag, 0);
      cmp_in = 16'd5;
      @(negedge clk);
      run(1);
      check("R7 immediate compare matched", match_flag, 1);

      // R2 reserved mode holds the counter
      do_reset(4'd0, 16'd0, 16'd0);
      run(7);
      mode = 4'd13;
      run(10);
      check("R2 reserved holds count", count, 7);
      check("R2 reserved no overflow", ovf_flag, 0);
      mode = 4'd0;
      run(1);
      check("R2 resumes after reserved", count, 8);

      finish_up();
   end

endmodule